// File: doc/BRIEF.md
# Two-Digit Decimal Totalizer with Saturating Alarm

This block counts events on a pulse input as a decimal number from 00 to 99. Each digit is kept as a 4-bit BCD nibble and drives its own decoder for an active-high seven-segment display. Every input is sampled on the system clock. A count step happens on the clock edge where the pulse input is first seen high.

The counter does nothing until the operator presses the reset switch, which arms it and shows 00. On reaching 99 it stops counting and drives a beeper. A silence switch mutes the beeper but keeps the count at 99. Only reset brings the counter back to 00.

Two shared control pairs act on every digit at once. One pair forces zero and the other forces nine. Each pair acts only when both of its inputs are high.

Top module: `bcd_totalizer`

## Requirements
- R1: After arming, each rising edge seen on `pulse_i` adds one to the count. The count moves on the clock edge where `pulse_i` is first sampled high. Holding `pulse_i` high for several cycles gives one step.
- R2: The units digit runs through 0 to 9. When it wraps from 9 to 0, the tens digit goes up by one in the same cycle (09 to 10, 19 to 20).
- R3: While `clr_a_i` and `clr_b_i` are both high and the preset pair is not both high, the next clock edge sets every digit to 0.
- R4: While `pre_a_i` and `pre_b_i` are both high, the next clock edge sets every digit to 9, whatever the clear pair is doing.
- R5: With only one input of a pair high, that pair has no effect and counting goes on as usual.
- R6: After `rst_n` the count is 00 and `beep_o` is low. Pulses that arrive before the first `arm_i` press leave the count at 00.
- R7: At count 99, `beep_o` is high and further pulses leave the count at 99.
- R8: Pressing `silence_i` while the beeper sounds drives `beep_o` low from the next cycle on, and the count stays at 99. Pressing `silence_i` at any other count has no effect: `beep_o` still rises when 99 is later reached.
- R9: `arm_i` high sets the count to 00 and drives `beep_o` low on the next edge. It has priority over pulses and over both control pairs.
- R10: Segment bits for each digit run a (bit 6) down to g (bit 0), active high, with these patterns:
  - 0 = 1111110
  - 1 = 0110000
  - 2 = 1101101
  - 3 = 1111001
  - 4 = 0110011
  - 5 = 1011011
  - 6 = 0011111
  - 7 = 1110000
  - 8 = 1111111
  - 9 = 1110011
- R11: Digit i sits at `bcd_o[4*i+3:4*i]` and `seg_o[7*i+6:7*i]`, with digit 0 as the units. Every nibble always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| pulse_i | input | 1 | Event input; each rising edge is one count |
| arm_i | input | 1 | Reset switch: arms the counter and clears it to 00 |
| silence_i | input | 1 | Mutes the beeper while the count is 99 |
| clr_a_i | input | 1 | Clear-to-zero gate, first input |
| clr_b_i | input | 1 | Clear-to-zero gate, second input |
| pre_a_i | input | 1 | Preset-to-nine gate, first input |
| pre_b_i | input | 1 | Preset-to-nine gate, second input |
| bcd_o | output | 8 | BCD digits, units in the low nibble |
| seg_o | output | 14 | Segment vectors, units in bits 6:0 |
| beep_o | output | 1 | Beeper drive |

## Verification
The bench builds the block with its default of two digits. With that setting the saturation point of 99 can be reached by counting, about a hundred pulses, and not only through the preset pair. So the run covers:
- every decimal carry on the way up;
- every segment pattern on both digits;
- the silence rules on an alarm reached by counting as well as on one forced by preset.

// File: rtl/totalizer_pkg.sv
package totalizer_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    typedef struct packed {
        logic armed;
        logic silenced;
    } ctrl_t;

    // Segment order: bit 6 = a ... bit 0 = g, active high
    function automatic logic [SEG_W-1:0] seg_of(input logic [DIGIT_W-1:0] v);
        logic [SEG_W-1:0] s;
        case (v)
            4'd0: s = 7'b1111110;
            4'd1: s = 7'b0110000;
            4'd2: s = 7'b1101101;
            4'd3: s = 7'b1111001;
            4'd4: s = 7'b0110011;
            4'd5: s = 7'b1011011;
            4'd6: s = 7'b0011111;
            4'd7: s = 7'b1110000;
            4'd8: s = 7'b1111111;
            4'd9: s = 7'b1110011;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d  = lvl_i;
        rise_o = lvl_i & ~lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/decade_digit.sv
module decade_digit
    import totalizer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               preset_i,
    input  logic               inc_i,
    output logic [DIGIT_W-1:0] value_o,
    output logic               nine_o
);
    localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(9);

    logic [DIGIT_W-1:0] value_d, value_q;

    // Priority: clear, then preset, then increment
    always_comb begin
        value_d = value_q;
        if (clear_i)
            value_d = '0;
        else if (preset_i)
            value_d = TOP;
        else if (inc_i)
            value_d = (value_q == TOP) ? '0 : value_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

    assign value_o = value_q;
    assign nine_o  = value_q[0] & value_q[3];
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
    import totalizer_pkg::*;
(
    input  logic [DIGIT_W-1:0] bcd_i,
    output logic [SEG_W-1:0]   seg_o
);
    always_comb seg_o = seg_of(bcd_i);
endmodule

// File: rtl/bcd_totalizer.sv
module bcd_totalizer
    import totalizer_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pulse_i,
    input  logic                      arm_i,
    input  logic                      silence_i,
    input  logic                      clr_a_i,
    input  logic                      clr_b_i,
    input  logic                      pre_a_i,
    input  logic                      pre_b_i,
    output logic [DIGITS*DIGIT_W-1:0] bcd_o,
    output logic [DIGITS*SEG_W-1:0]   seg_o,
    output logic                      beep_o
);
    logic              rise;
    logic              load_zero, load_nine, all_nine;
    logic [DIGITS-1:0] nine, carry;
    ctrl_t             ctrl_d, ctrl_q;

    rise_detect u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pulse_i),
        .rise_o (rise)
    );

    always_comb begin
        load_nine = pre_a_i & pre_b_i & ~arm_i;
        load_zero = arm_i | (clr_a_i & clr_b_i & ~(pre_a_i & pre_b_i));
        all_nine  = &nine;
        carry[0]  = rise & ctrl_q.armed & ~all_nine;

        ctrl_d.armed    = ctrl_q.armed | arm_i;
        ctrl_d.silenced = arm_i ? 1'b0 : (all_nine & (ctrl_q.silenced | silence_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        if (i > 0) begin : g_carry
            assign carry[i] = carry[i-1] & nine[i-1];
        end

        decade_digit u_digit (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (load_zero),
            .preset_i (load_nine),
            .inc_i    (carry[i]),
            .value_o  (bcd_o[i*DIGIT_W +: DIGIT_W]),
            .nine_o   (nine[i])
        );

        seg_decoder u_seg (
            .bcd_i (bcd_o[i*DIGIT_W +: DIGIT_W]),
            .seg_o (seg_o[i*SEG_W +: SEG_W])
        );
    end

    assign beep_o = all_nine & ~ctrl_q.silenced;
endmodule

// File: rtl/totalizer_chk.sv
module totalizer_chk #(
    parameter int DIGITS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                arm_i,
    input logic                silence_i,
    input logic                clr_a_i,
    input logic                clr_b_i,
    input logic                pre_a_i,
    input logic                pre_b_i,
    input logic [DIGITS*4-1:0] bcd_o,
    input logic                beep_o
);
    localparam logic [DIGITS*4-1:0] NINES = {DIGITS{4'h9}};

    a_r3_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a_i && clr_b_i && !(pre_a_i && pre_b_i)) |=> (bcd_o == '0));

    a_r4_preset_to_nine: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_a_i && pre_b_i && !arm_i) |=> (bcd_o == NINES));

    a_r7_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd_o == NINES && !arm_i && !(clr_a_i && clr_b_i)) |=> (bcd_o == NINES));

    a_r7_beep_only_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        beep_o |-> (bcd_o == NINES));

    a_r8_silence_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        (beep_o && silence_i) |=> !beep_o);

    a_r9_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (bcd_o == '0 && !beep_o));

    for (genvar i = 0; i < DIGITS; i++) begin : g_nib
        a_r11_nibble_range: assert property (@(posedge clk) disable iff (!rst_n)
            bcd_o[i*4 +: 4] <= 4'd9);
    end
endmodule

bind bcd_totalizer totalizer_chk #(.DIGITS(DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_i),
    .silence_i (silence_i),
    .clr_a_i   (clr_a_i),
    .clr_b_i   (clr_b_i),
    .pre_a_i   (pre_a_i),
    .pre_b_i   (pre_b_i),
    .bcd_o     (bcd_o),
    .beep_o    (beep_o)
);

// File: tb/bcd_totalizer_tb_top.sv
`timescale 1ns/1ps
module bcd_totalizer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_i = 1'b0, arm_i = 1'b0, silence_i = 1'b0;
    logic        clr_a_i = 1'b0, clr_b_i = 1'b0, pre_a_i = 1'b0, pre_b_i = 1'b0;
    logic [7:0]  bcd_o;
    logic [13:0] seg_o;
    logic        beep_o;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    bcd_totalizer #(.DIGITS(2)) dut_i (.*);

    function automatic logic [6:0] exp_seg(int d);
        case (d)
            0: return 7'b1111110;  1: return 7'b0110000;
            2: return 7'b1101101;  3: return 7'b1111001;
            4: return 7'b0110011;  5: return 7'b1011011;
            6: return 7'b0011111;  7: return 7'b1110000;
            8: return 7'b1111111;  9: return 7'b1110011;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic check_count(int n, string req);
        int e = ((n / 10) << 4) | (n % 10);
        check(bcd_o == 8'(e), req, "count", int'(bcd_o), e);
        check(seg_o[6:0] == exp_seg(n % 10), {req, "/R10"}, "units seg",
              int'(seg_o[6:0]), int'(exp_seg(n % 10)));
        check(seg_o[13:7] == exp_seg(n / 10), {req, "/R11"}, "tens seg",
              int'(seg_o[13:7]), int'(exp_seg(n / 10)));
    endtask

    task automatic check_beep(bit e, string req);
        check(beep_o == e, req, "beep", int'(beep_o), int'(e));
    endtask

    task automatic pulse();
        @(negedge clk) pulse_i = 1'b1;
        @(negedge clk) pulse_i = 1'b0;
    endtask

    task automatic press_arm();
        @(negedge clk) arm_i = 1'b1;
        @(negedge clk) arm_i = 1'b0;
    endtask

    task automatic t_reset_state();
        check_count(0, "R6");
        check_beep(1'b0, "R6");
    endtask

    task automatic t_unarmed();
        for (int i = 0; i < 3; i++) pulse();
        check_count(0, "R6");
    endtask

    task automatic t_count_up();
        press_arm();
        check_count(0, "R9");
        for (int n = 1; n <= 21; n++) begin
            pulse();
            check_count(n, (n % 10 == 0) ? "R2" : "R1");
        end
    endtask

    task automatic t_hold_high();
        @(negedge clk) pulse_i = 1'b1;
        repeat (4) @(negedge clk);
        pulse_i = 1'b0;
        @(negedge clk);
        check_count(22, "R1");
    endtask

    task automatic t_half_pairs();
        @(negedge clk) begin clr_a_i = 1'b1; pre_b_i = 1'b1; end
        pulse();
        check_count(23, "R5");
        @(negedge clk) begin clr_a_i = 1'b0; pre_b_i = 1'b0; clr_b_i = 1'b1; pre_a_i = 1'b1; end
        pulse();
        check_count(24, "R5");
        @(negedge clk) begin clr_b_i = 1'b0; pre_a_i = 1'b0; end
    endtask

    task automatic t_clear();
        @(negedge clk) begin clr_a_i = 1'b1; clr_b_i = 1'b1; end
        @(negedge clk) begin clr_a_i = 1'b0; clr_b_i = 1'b0; end
        check_count(0, "R3");
    endtask

    task automatic t_preset_and_alarm();
        @(negedge clk) begin clr_a_i = 1'b1; clr_b_i = 1'b1; pre_a_i = 1'b1; pre_b_i = 1'b1; end
        @(negedge clk) begin clr_a_i = 1'b0; clr_b_i = 1'b0; pre_a_i = 1'b0; pre_b_i = 1'b0; end
        check_count(99, "R4");
        check_beep(1'b1, "R7");
        pulse();
        pulse();
        check_count(99, "R7");
        check_beep(1'b1, "R7");
    endtask

    task automatic t_silence();
        @(negedge clk) silence_i = 1'b1;
        @(negedge clk) silence_i = 1'b0;
        check_beep(1'b0, "R8");
        check_count(99, "R8");
        pulse();
        check_count(99, "R8");
        check_beep(1'b0, "R8");
    endtask

    task automatic t_arm_priority();
        @(negedge clk) begin arm_i = 1'b1; pulse_i = 1'b1; pre_a_i = 1'b1; pre_b_i = 1'b1; end
        @(negedge clk) begin arm_i = 1'b0; pulse_i = 1'b0; pre_a_i = 1'b0; pre_b_i = 1'b0; end
        check_count(0, "R9");
        check_beep(1'b0, "R9");
    endtask

    task automatic t_full_run();
        pulse();
        pulse();
        check_count(2, "R1");
        // silence away from 99 must not mute the later alarm
        @(negedge clk) silence_i = 1'b1;
        @(negedge clk) silence_i = 1'b0;
        check_count(2, "R8");
        check_beep(1'b0, "R8");
        for (int n = 3; n <= 99; n++) begin
            pulse();
            check_count(n, (n % 10 == 0) ? "R2" : "R1");
        end
        check_beep(1'b1, "R8");
        pulse();
        check_count(99, "R7");
        press_arm();
        check_count(0, "R9");
        check_beep(1'b0, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_unarmed();
        t_count_up();
        t_hold_high();
        t_half_pairs();
        t_clear();
        t_preset_and_alarm();
        t_silence();
        t_arm_priority();
        t_full_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule